// File: doc/BRIEF.md
# Threshold-Gated Burst Request Scheduler

This block decides when and how a display layer refills its pixel FIFO from system memory. A transfer begins when a word count and a start address are loaded. From then on the scheduler issues read-burst requests to a separate bus engine, one at a time. It only starts a burst once the FIFO reports enough free room for the preferred burst size. The preferred size comes from a 3-bit field that software may write only while a protection bit is low.

Each request carries a beat count, a burst-type code and an address. The scheduler uses the preferred size while enough words remain. For the last part of a transfer it steps down a fixed ladder of smaller sizes (16, 8, 4), never going above the preferred size. Any tail shorter than four words is fetched one beat at a time. The preferred size is captured when a transfer starts, so a write to the field during a transfer only affects the next one.

Top module: `burst_sched`

## Requirements
- R1: Field codes 0, 1, 2, 3 and 4 select a preferred size of 1, 4, 8, 16 and 32 beats. `req_type` reports the size of each burst as 0=single, 1=4 beats, 2=8 beats, 3=16 beats, 4=32 beats.
- R2: A field value of 5, 6 or 7 behaves exactly like code 0: every request is a single beat.
- R3: No request is raised while `fifo_free` is below the preferred size of the active code. A request is raised in the cycle after `fifo_free` reaches that size (one free word for code 0).
- R4: While the words left in the transfer are at least the preferred size, each burst is the preferred size.
- R5: When between 4 words and one less than the preferred size remain, the burst is the largest of 16, 8 and 4 beats that fits in the remaining words and does not exceed the preferred size.
- R6: When fewer than 4 words remain, each request is a single beat.
- R7: The field resets to 0. A write is accepted only when `cfg_wr_en` is high and `cfg_wp` is low; otherwise the field keeps its value.
- R8: Only one request is outstanding at a time. `req_valid`, `req_beats`, `req_type` and `req_addr` stay constant until `bus_done`. `req_valid` is low in the cycle after `bus_done`.
- R9: The first burst of a transfer uses the loaded start address. Each completed burst advances the address by its beat count times `WORD_BYTES` (4) and reduces the words left by its beat count. The transfer ends (`xfer_busy` low) when no words are left.
- R10: The field value is captured at transfer start. A field write during a transfer does not change the remaining bursts of that transfer, but it applies to the next transfer.
- R11: `xfer_start` is ignored while `xfer_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the burst-size field |
| cfg_wr_data | input | 3 | New burst-size code |
| cfg_wp | input | 1 | Write protection; blocks field writes when high |
| xfer_start | input | 1 | Loads a new transfer when idle |
| xfer_words | input | CNT_W (12) | Word count of the new transfer |
| xfer_addr | input | ADDR_W (32) | Byte start address of the new transfer |
| fifo_free | input | FREE_W (7) | Free word slots in the pixel FIFO |
| bus_done | input | 1 | Bus engine finished the current burst |
| req_valid | output | 1 | Burst request outstanding |
| req_beats | output | 6 | Beats in the requested burst |
| req_type | output | 3 | Burst-type code (see R1) |
| req_addr | output | ADDR_W (32) | Byte address of the requested burst |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
The main sweep runs every field code from 0 to 7 against every transfer length from 1 to 40 words. This covers lengths at, above and below each preferred size. It separates the plain preferred-size case, each rung of the step-down ladder, the single-beat tail, and the reserved codes that must match code 0.

The FIFO gate is tested by holding free space one word below the threshold and then raising it to the threshold. This shows the exact cycle in which the request appears. In a separate transfer, a protected write, an unprotected write made mid-transfer, and a repeated start pulse are each applied. The resulting burst sequences then show which of these took effect and when.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int BEAT_W = 6;

  typedef enum logic [2:0] {
    BT_SINGLE = 3'd0,
    BT_INCR4  = 3'd1,
    BT_INCR8  = 3'd2,
    BT_INCR16 = 3'd3,
    BT_INCR32 = 3'd4
  } burst_t;

  // Reserved codes collapse onto single beats.
  function automatic logic [2:0] legal_code(input logic [2:0] c);
    return (c > 3'd4) ? 3'd0 : c;
  endfunction

  function automatic logic [BEAT_W-1:0] beats_of(input burst_t t);
    logic [BEAT_W-1:0] b;
    if (t == BT_SINGLE) b = 6'd1;
    else                b = 6'd1 << (3'(t) + 3'd1);
    return b;
  endfunction

  function automatic logic [BEAT_W-1:0] pref_beats(input logic [2:0] c);
    return beats_of(burst_t'(legal_code(c)));
  endfunction

  // rem_cap holds the remaining words clamped to 32.
  function automatic burst_t ladder_pick(input logic [2:0] code,
                                         input logic [BEAT_W-1:0] rem_cap);
    logic [BEAT_W-1:0] p;
    burst_t t;
    p = pref_beats(code);
    if (rem_cap >= p)                          t = burst_t'(legal_code(code));
    else if (p > 6'd16 && rem_cap >= 6'd16)    t = BT_INCR16;
    else if (p > 6'd8  && rem_cap >= 6'd8)     t = BT_INCR8;
    else if (p > 6'd4  && rem_cap >= 6'd4)     t = BT_INCR4;
    else                                       t = BT_SINGLE;
    return t;
  endfunction

endpackage

// File: rtl/bsch_cfg.sv
module bsch_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  input  logic       wp,
  output logic [2:0] field_q
);

  logic wr_accept;
  assign wr_accept = wr_en && !wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         field_q <= 3'd0;
    else if (wr_accept) field_q <= wr_data;
  end

  // R7: a protected cycle never changes the field
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> $stable(field_q));

endmodule

// File: rtl/bsch_pick.sv
module bsch_pick #(
  parameter int CNT_W  = 12,
  parameter int FREE_W = 7
) (
  input  logic [2:0]                 code,
  input  logic [CNT_W-1:0]           rem,
  input  logic [FREE_W-1:0]          fifo_free,
  output logic [burst_pkg::BEAT_W-1:0] thresh,
  output logic                       room_ok,
  output burst_pkg::burst_t          pick_type,
  output logic [burst_pkg::BEAT_W-1:0] pick_beats
);
  import burst_pkg::*;

  logic [BEAT_W-1:0] rem_cap;

  always_comb begin
    rem_cap    = (int'(rem) >= 32) ? 6'd32 : rem[BEAT_W-1:0];
    thresh     = pref_beats(code);
    room_ok    = int'(fifo_free) >= int'(thresh);
    pick_type  = ladder_pick(code, rem_cap);
    pick_beats = beats_of(pick_type);
  end

endmodule

// File: rtl/bsch_track.sv
module bsch_track #(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 32,
  parameter int FREE_W     = 7,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer_start,
  input  logic [CNT_W-1:0]             xfer_words,
  input  logic [ADDR_W-1:0]            xfer_addr,
  input  logic [2:0]                   cfg_field,
  input  logic [FREE_W-1:0]            fifo_free,
  input  logic [burst_pkg::BEAT_W-1:0] thresh,
  input  logic                         room_ok,
  input  burst_pkg::burst_t            pick_type,
  input  logic [burst_pkg::BEAT_W-1:0] pick_beats,
  input  logic                         bus_done,
  output logic [2:0]                   active_code,
  output logic [CNT_W-1:0]             rem_q,
  output logic                         req_valid,
  output logic [burst_pkg::BEAT_W-1:0] req_beats,
  output logic [2:0]                   req_type,
  output logic [ADDR_W-1:0]            req_addr,
  output logic                         xfer_busy
);
  import burst_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic              load_ev;
  logic              done_ev;
  logic              issue_ev;

  assign xfer_busy = req_valid || (rem_q != '0);
  assign load_ev   = !xfer_busy && xfer_start && (xfer_words != '0);
  assign done_ev   = req_valid && bus_done;
  assign issue_ev  = !req_valid && (rem_q != '0) && room_ok;
  assign req_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q       <= '0;
      addr_q      <= '0;
      active_code <= 3'd0;
      req_valid   <= 1'b0;
      req_beats   <= '0;
      req_type    <= 3'd0;
    end else if (load_ev) begin
      rem_q       <= xfer_words;
      addr_q      <= xfer_addr;
      active_code <= legal_code(cfg_field);
    end else if (done_ev) begin
      req_valid <= 1'b0;
      rem_q     <= rem_q - CNT_W'(req_beats);
      addr_q    <= addr_q + ADDR_W'(req_beats) * ADDR_W'(WORD_BYTES);
    end else if (issue_ev) begin
      req_valid <= 1'b1;
      req_beats <= pick_beats;
      req_type  <= 3'(pick_type);
    end
  end

  // R3: a request only rises after the FIFO had room for the preferred size
  p_fifo_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> int'($past(fifo_free)) >= int'($past(thresh)));

  // R8: request fields are held until the bus engine completes
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_done) |=> (req_valid && $stable(req_beats)
                                  && $stable(req_type) && $stable(req_addr)));

  // R8: completion drops the request for at least one cycle
  p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bus_done) |=> !req_valid);

  // R1: every burst is a power-of-two beat count within the transfer
  p_beats_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(req_beats) == 1) && (int'(req_beats) <= int'(rem_q)));

  // R6: short tails are single beats
  p_tail_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(rem_q) < 4) |-> req_beats == 6'd1);

  // R2: the captured code is never a reserved value
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_code <= 3'd4);

  // R10/R11: the captured code cannot move while a transfer runs
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> $stable(active_code));

endmodule

// File: rtl/burst_sched.sv
module burst_sched #(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 32,
  parameter int FREE_W     = 7,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_wr_data,
  input  logic              cfg_wp,
  input  logic              xfer_start,
  input  logic [CNT_W-1:0]  xfer_words,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              bus_done,
  output logic              req_valid,
  output logic [5:0]        req_beats,
  output logic [2:0]        req_type,
  output logic [ADDR_W-1:0] req_addr,
  output logic              xfer_busy
);
  import burst_pkg::*;

  logic [2:0]        cfg_field;
  logic [2:0]        active_code;
  logic [CNT_W-1:0]  rem_q;
  logic [BEAT_W-1:0] thresh;
  logic              room_ok;
  burst_t            pick_type;
  logic [BEAT_W-1:0] pick_beats;

  bsch_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .wp      (cfg_wp),
    .field_q (cfg_field)
  );

  bsch_pick #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_pick (
    .code       (active_code),
    .rem        (rem_q),
    .fifo_free  (fifo_free),
    .thresh     (thresh),
    .room_ok    (room_ok),
    .pick_type  (pick_type),
    .pick_beats (pick_beats)
  );

  bsch_track #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .FREE_W(FREE_W),
               .WORD_BYTES(WORD_BYTES)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_start  (xfer_start),
    .xfer_words  (xfer_words),
    .xfer_addr   (xfer_addr),
    .cfg_field   (cfg_field),
    .fifo_free   (fifo_free),
    .thresh      (thresh),
    .room_ok     (room_ok),
    .pick_type   (pick_type),
    .pick_beats  (pick_beats),
    .bus_done    (bus_done),
    .active_code (active_code),
    .rem_q       (rem_q),
    .req_valid   (req_valid),
    .req_beats   (req_beats),
    .req_type    (req_type),
    .req_addr    (req_addr),
    .xfer_busy   (xfer_busy)
  );

endmodule

// File: tb/burst_sched_tb.sv
module burst_sched_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_data = 3'd0;
  logic        cfg_wp = 1'b0;
  logic        xfer_start = 1'b0;
  logic [11:0] xfer_words = '0;
  logic [31:0] xfer_addr = '0;
  logic [6:0]  fifo_free = 7'd127;
  logic        bus_done = 1'b0;
  logic        req_valid;
  logic [5:0]  req_beats;
  logic [2:0]  req_type;
  logic [31:0] req_addr;
  logic        xfer_busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_wp(cfg_wp), .xfer_start(xfer_start), .xfer_words(xfer_words),
    .xfer_addr(xfer_addr), .fifo_free(fifo_free), .bus_done(bus_done),
    .req_valid(req_valid), .req_beats(req_beats), .req_type(req_type),
    .req_addr(req_addr), .xfer_busy(xfer_busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Preferred size from the code, reserved codes acting as code 0
  function automatic int model_pref(input int code);
    int c = (code > 4) ? 0 : code;
    return (c == 0) ? 1 : (2 ** (c + 1));
  endfunction

  function automatic int model_beats(input int code, input int rem);
    int p = model_pref(code);
    if (rem >= p) return p;
    for (int s = 16; s >= 4; s = s / 2)
      if (s < p && s <= rem) return s;
    return 1;
  endfunction

  function automatic int model_type(input int beats);
    int t = 0;
    int v = beats;
    while (v > 1) begin v = v / 2; t++; end
    return (t == 0) ? 0 : t - 1;
  endfunction

  task automatic write_cfg(input int code, input bit wp);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 3'(code); cfg_wp = wp;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wp = 1'b0;
  endtask

  task automatic pulse_start(input int words, input int base);
    @(negedge clk);
    xfer_start = 1'b1; xfer_words = 12'(words); xfer_addr = 32'(base);
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  // Serve all bursts of a transfer; poke injects a mid-transfer write and start
  task automatic serve(input int code, input int words, input int base,
                       input bit poke, input string tag);
    int rem = words;
    int addr = base;
    bit first = 1'b1;
    while (rem > 0) begin
      int k = 0;
      int eb;
      while (!req_valid && k < 60) begin @(negedge clk); k++; end
      eb = model_beats(code, rem);
      chk({tag, " req seen R8"}, req_valid, 1);
      chk({tag, " beats R4 R5 R6"}, req_beats, eb);
      chk({tag, " type R1"}, req_type, model_type(eb));
      chk({tag, " addr R9"}, req_addr, addr);
      if (first) begin
        @(negedge clk);
        chk({tag, " held R8"}, {req_valid, req_beats}, {1'b1, 6'(eb)});
      end
      bus_done = 1'b1;
      if (poke && first) begin
        cfg_wr_en = 1'b1; cfg_wr_data = 3'd4;
        xfer_start = 1'b1; xfer_words = 12'd5; xfer_addr = 32'hDEAD0000;
      end
      @(negedge clk);
      bus_done = 1'b0; cfg_wr_en = 1'b0; xfer_start = 1'b0;
      chk({tag, " drop after done R8"}, req_valid, 0);
      rem -= eb;
      addr += eb * 4;
      first = 1'b0;
    end
    chk({tag, " end busy R9 R11"}, xfer_busy, 0);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset req_valid R8", req_valid, 0);
    chk("reset busy R9", xfer_busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: field resets to 0, so single beats
    pulse_start(6, 32'h100);
    serve(0, 6, 32'h100, 1'b0, "reset field R7");

    // R1 R2 R4 R5 R6 R9 sweep
    for (int code = 0; code < 8; code++) begin
      write_cfg(code, 1'b0);
      for (int w = 1; w <= 40; w++) begin
        pulse_start(w, 32'h1000 + w * 256);
        serve(code, w, 32'h1000 + w * 256, 1'b0, (code > 4) ? "sweep R2" : "sweep");
      end
    end

    // R7: protected write ignored
    write_cfg(1, 1'b0);
    write_cfg(4, 1'b1);
    pulse_start(32, 32'h4000);
    serve(1, 32, 32'h4000, 1'b0, "protected R7");

    // R3: threshold gate with code 3 (16 beats)
    write_cfg(3, 1'b0);
    fifo_free = 7'd15;
    pulse_start(40, 32'h8000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("below threshold R3", req_valid, 0);
    end
    fifo_free = 7'd16;
    @(negedge clk);
    chk("at threshold R3", req_valid, 1);
    fifo_free = 7'd127;
    serve(3, 40, 32'h8000, 1'b0, "gate R3");

    // R3: code 0 needs one free word
    write_cfg(0, 1'b0);
    fifo_free = 7'd0;
    pulse_start(2, 32'h9000);
    repeat (4) begin
      @(negedge clk);
      chk("code0 empty R3", req_valid, 0);
    end
    fifo_free = 7'd1;
    @(negedge clk);
    chk("code0 one word R3", req_valid, 1);
    serve(0, 2, 32'h9000, 1'b0, "code0 gate R3");
    fifo_free = 7'd127;

    // R10 R11: mid-transfer write and start ignored for this transfer
    write_cfg(2, 1'b0);
    pulse_start(24, 32'hA000);
    serve(2, 24, 32'hA000, 1'b1, "mid write R10 R11");
    pulse_start(32, 32'hB000);
    serve(4, 32, 32'hB000, 1'b0, "next xfer R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule